// File: doc/BRIEF.md
# Toggle-Handshake Dual-Edge RAM Port

This block wraps a single-port word memory for a generated datapath state machine. The datapath asks for an access by raising a one-cycle request strobe together with an address, a write-enable and, for stores, a data word. On that rising clock edge the block inverts a request-toggle flag and registers the access. The memory side runs on the falling clock edge. It compares the toggle with its own enable flag and performs the access only when the two differ. Then it copies the toggle into its flag, which closes the access until the next inversion.

A load places the addressed word in a read-data register on the falling edge. On the next rising edge the block moves that word into a destination register and pulses an update flag. A store is written on the falling edge, so it is complete before the next rising edge. A request can therefore be issued on every cycle with no acknowledge and no stall. The memory holds 32-bit words, its depth is a parameter, and addresses are word indices.

Top module: `toggle_ram_port`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_word` and `dst_word` are zero and `dst_upd` is low. The request toggle and the memory enable flag reset to the same value, so no access takes place out of reset.
- R2: Every rising edge with `acc_valid` high inverts the request toggle. A rising edge with `acc_valid` low leaves it unchanged.
- R3: A load (`acc_valid` high, `acc_we` low) sampled at rising edge k places the word at `acc_addr` on `rd_word` at the falling edge that follows, before rising edge k+1.
- R4: At rising edge k+1 after a load at edge k, `dst_word` takes the loaded word and `dst_upd` is high for exactly that one cycle.
- R5: A store (`acc_valid` high, `acc_we` high) sampled at rising edge k writes `acc_wdata` at the falling edge that follows. A load of the same address at edge k+1 returns the new word.
- R6: A store does not change `rd_word` or `dst_word`, and `dst_upd` stays low in the cycle after it.
- R7: A cycle with `acc_valid` low leaves the memory contents and `rd_word` unchanged, and `dst_upd` is low in the cycle after it.
- R8: Requests issued on consecutive rising edges, in any mix of loads and stores, each complete within their own clock cycle.
- R9: At every rising edge after reset, the memory enable flag already equals the request toggle. Each request therefore enables the memory on exactly one falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; requests are taken on the rising edge, the memory acts on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request for this rising edge |
| acc_we | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Word index, ADDR_W = clog2(DEPTH) |
| acc_wdata | input | DATA_W | Word to store |
| rd_word | output | DATA_W | Read-data register, updated on the falling edge of a load |
| dst_word | output | DATA_W | Destination register, loaded from rd_word on the rising edge after a load |
| dst_upd | output | 1 | High for the cycle in which dst_word has just taken a load result |

## Verification
The checker samples on every rising edge. It checks four things there: the toggle inverts exactly when a request is present, the memory flag has caught up with the toggle, rd_word holds still across stores and idle cycles, and a load reaches dst_word with the update flag two samples later. Some behaviours can only be shown by the bench's scenarios, which compare every cycle against a behavioural memory model: that the data read comes from the right address, that a store is visible to a load on the very next cycle, and that back-to-back mixed traffic returns the correct words.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [0:0] {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/trp_req_side.sv
// Rising-edge half: turns a request strobe into a toggle plus a registered
// access, and captures load results into the destination register.
module trp_req_side
    import trp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] req_addr,
    output acc_kind_e         req_kind,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] dst_word,
    output logic              dst_upd
);

    typedef struct packed {
        logic              tgl;
        logic [ADDR_W-1:0] addr;
        acc_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic              ld_pend;
        logic [DATA_W-1:0] dst;
        logic              upd;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        // a load issued last edge has its word in rd_word by now
        if (st_q.ld_pend) begin
            st_d.dst = rd_word;
            st_d.upd = 1'b1;
        end
        st_d.ld_pend = 1'b0;
        if (acc_valid) begin
            st_d.tgl  = ~st_q.tgl;
            st_d.addr = acc_addr;
            if (acc_we) begin
                st_d.kind  = ACC_STORE;
                st_d.wdata = acc_wdata;
            end else begin
                st_d.kind    = ACC_LOAD;
                st_d.ld_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tgl: 1'b0, addr: '0, kind: ACC_LOAD, wdata: '0,
                      ld_pend: 1'b0, dst: '0, upd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_tgl   = st_q.tgl;
    assign req_addr  = st_q.addr;
    assign req_kind  = st_q.kind;
    assign req_wdata = st_q.wdata;
    assign dst_word  = st_q.dst;
    assign dst_upd   = st_q.upd;

endmodule

// File: rtl/trp_ram_side.sv
// Falling-edge half: the memory acts only when the toggle differs from its
// own enable flag, then copies the toggle to close the access.
module trp_ram_side
    import trp_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = $clog2(DEPTH),
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic [ADDR_W-1:0] req_addr,
    input  acc_kind_e         req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ram_en,
    output logic [DATA_W-1:0] rd_word
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] rd;
    } ram_state_t;

    ram_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic go;

    assign go = (req_tgl != st_q.en);

    always_comb begin
        st_d = st_q;
        if (go) begin
            st_d.en = req_tgl;
            if (req_kind == ACC_LOAD) begin
                st_d.rd = mem[req_addr];
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, rd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(negedge clk) begin
        if (rst_n && go && req_kind == ACC_STORE) begin
            mem[req_addr] <= req_wdata;
        end
    end

    assign ram_en  = st_q.en;
    assign rd_word = st_q.rd;

endmodule

// File: rtl/toggle_ram_port.sv
module toggle_ram_port
    import trp_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dst_word,
    output logic              dst_upd
);

    logic              req_tgl;
    logic [ADDR_W-1:0] req_addr;
    acc_kind_e         req_kind;
    logic [DATA_W-1:0] req_wdata;
    logic              ram_en;

    trp_req_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_word   (rd_word),
        .req_tgl   (req_tgl),
        .req_addr  (req_addr),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .dst_word  (dst_word),
        .dst_upd   (dst_upd)
    );

    trp_ram_side #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .req_addr  (req_addr),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .ram_en    (ram_en),
        .rd_word   (rd_word)
    );

endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_we,
    input logic              req_tgl,
    input logic              ram_en,
    input logic [DATA_W-1:0] rd_word,
    input logic [DATA_W-1:0] dst_word,
    input logic              dst_upd
);

    // R2: each request inverts the toggle, idle cycles hold it
    p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (req_tgl != $past(req_tgl)));
    p_toggle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(req_tgl));

    // R9 (and R1): the falling edge has always closed the access by the next rising edge
    p_en_caught_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en == req_tgl);

    // R6: a store leaves the read register alone
    p_store_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we) |=> $stable(rd_word));

    // R7: no request, no read
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(rd_word) ##1 !dst_upd);

    // R4: a load's word reaches the destination with the update pulse
    p_dst_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we) |=> ##1 (dst_upd && dst_word == $past(rd_word)));

endmodule

bind toggle_ram_port trp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .req_tgl   (req_tgl),
    .ram_en    (ram_en),
    .rd_word   (rd_word),
    .dst_word  (dst_word),
    .dst_upd   (dst_upd)
);

// File: tb/toggle_ram_port_tb.sv
module toggle_ram_port_tb;

    localparam int unsigned DEPTH  = 256;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned NWIN   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_we = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dst_word;
    logic              dst_upd;

    always #2ns clk = ~clk;  // 250 MHz

    toggle_ram_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_word   (rd_word),
        .dst_word  (dst_word),
        .dst_upd   (dst_upd)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference
    logic [DATA_W-1:0] ref_mem [NWIN];
    logic [DATA_W-1:0] exp_rd  = '0;
    logic [DATA_W-1:0] exp_dst = '0;
    logic              exp_upd = 1'b0;
    bit                ld_last = 1'b0;
    logic [31:0]       seed    = 32'h1234_5678;

    function automatic logic [31:0] next_rand(logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic chk(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one cycle: inputs set after the falling edge, taken at the rising edge,
    // outputs sampled after the following falling edge
    task automatic cyc(bit v, bit we, int a, logic [DATA_W-1:0] d, string req);
        acc_valid = v;
        acc_we    = we;
        acc_addr  = ADDR_W'(a);
        acc_wdata = d;
        @(posedge clk);
        exp_upd = 1'b0;
        if (ld_last) begin
            exp_dst = exp_rd;
            exp_upd = 1'b1;
        end
        ld_last = 1'b0;
        if (v) begin
            if (we) ref_mem[a] = d;
            else begin
                exp_rd  = ref_mem[a];
                ld_last = 1'b1;
            end
        end
        #3ns;
        chk(req, "rd_word", rd_word, exp_rd);
        chk(req, "dst_word", dst_word, exp_dst);
        chk(req, "dst_upd", {31'b0, dst_upd}, {31'b0, exp_upd});
    endtask

    initial begin
        #(200000 * 4ns);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1ns;
        // R1: outputs during reset
        chk("R1", "rd_word", rd_word, '0);
        chk("R1", "dst_word", dst_word, '0);
        chk("R1", "dst_upd", {31'b0, dst_upd}, '0);
        #2ns;
        rst_n = 1'b1;
        // R1: first cycle idle after reset shows no access
        cyc(1'b0, 1'b0, 0, '0, "R1");

        // R5 R8: back-to-back stores filling the window
        for (int i = 0; i < NWIN; i++) begin
            seed = next_rand(seed);
            cyc(1'b1, 1'b1, i, seed, "R5");
        end
        // R6: stores left the read side untouched (checked each cycle above)
        cyc(1'b0, 1'b0, 0, '0, "R6");

        // R3 R4 R8: back-to-back loads in reverse order
        for (int i = NWIN - 1; i >= 0; i--) cyc(1'b1, 1'b0, i, '0, "R3");
        cyc(1'b0, 1'b0, 0, '0, "R4");

        // R5: store then immediate load of the same address
        for (int i = 0; i < 8; i++) begin
            seed = next_rand(seed);
            cyc(1'b1, 1'b1, i * 3, seed, "R5");
            cyc(1'b1, 1'b0, i * 3, '0, "R5");
        end

        // R7: idle cycles, then read back to see memory unchanged
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 7, 32'hDEAD_BEEF, "R7");
        cyc(1'b1, 1'b0, 7, '0, "R7");
        cyc(1'b0, 1'b0, 0, '0, "R7");

        // R6 R8 R9: mixed traffic, a load followed by stores keeps dst steady
        for (int i = 0; i < 200; i++) begin
            seed = next_rand(seed);
            cyc(1'b1, seed[3], int'(seed[12:8]) % NWIN, next_rand(seed), "R8");
        end
        cyc(1'b0, 1'b0, 0, '0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule